// File: doc/BRIEF.md
# Target Selection and Bus Reset Detector

This block sits on the target side of a parallel SCSI-style bus. It watches the select, busy, attention and reset lines and the 8-bit data bus. It recognises when an initiator is selecting one of the device IDs this target answers to. Up to eight ID slots can be configured, and each slot has an enable bit and a 3-bit ID. When a selection matches, the block records the outcome, takes the bus by driving busy, and drives the command/data and message lines at their inactive level. After a settle interval it samples attention. If attention is low at that point, the initiator is treated as an older host that sends no identify message, and a compatibility flag is raised.

In parallel, a glitch filter qualifies the bus reset line. A rising edge of reset arms the filter, and a second sample is taken a fixed interval later. The reset flag is raised only if both samples see reset asserted. A reset edge is ignored while the target's own select driver is enabled, because the target may then be the cause of the activity on the line. A bus-free request from the controlling logic clears the selection status and the reset flag, and it releases every output enable. Command execution and data transfer belong to other blocks.

All bus inputs use active-high logical levels and pass through two-flop synchronizers. The settle interval and the reset interval are given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `tsr_target_sel`

## Requirements
- R1: After synchronous reset, every output is 0 (sel_ok, sel_atn, sel_id, scsi1_mode, bus_reset_seen, bsy_oe, ctl_oe).
- R2: A selection is accepted only while bus_sel is high and bus_bsy is low; while bus_bsy is high nothing is selected, and the selection goes ahead once bus_bsy falls.
- R3: Bit n of bus_data set means ID n is being selected. The enabled slot with the lowest index whose ID bit is set wins, disabled slots are skipped, and when no enabled slot matches, no selection takes place.
- R4: On a match, sel_ok goes to 1, sel_atn is provisionally set to 1, sel_id takes the matching 3-bit ID, and bsy_oe and ctl_oe both go to 1.
- R5: The selection status stays latched after the initiator drops bus_sel, until a bus-free request.
- R6: Attention is sampled SETTLE_NS after bsy_oe rises, and not before. If bus_atn is low at that point, sel_atn clears and scsi1_mode goes to 1. If bus_atn is high, sel_atn stays at 1 and scsi1_mode goes to 0.
- R7: While bsy_oe is 1, changes on bus_sel, bus_bsy and bus_data do not alter the selection status.
- R8: bus_reset_seen is set only when a rising edge of bus_rst is followed by bus_rst still high RST_GAP_NS later; a shorter pulse leaves it at 0.
- R9: A bus_rst rising edge that arrives while own_sel_oe is 1 never sets bus_reset_seen.
- R10: A bus_free_req pulse clears sel_ok, sel_atn, sel_id, bus_reset_seen, bsy_oe and ctl_oe on the next clock; scsi1_mode keeps its value.
- R11: An initiator that raises bus_sel without ever asserting bus_bsy is selected just the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Select line, 1 = asserted |
| bus_bsy | input | 1 | Busy line, 1 = asserted |
| bus_atn | input | 1 | Attention line, 1 = asserted |
| bus_rst | input | 1 | Bus reset line, 1 = asserted |
| bus_data | input | 8 | Data bus, read as a mask of IDs |
| slot_en | input | 8 | Per-slot enable |
| slot_id | input | 24 | Per-slot 3-bit ID, slot k at bits 3k+2..3k |
| own_sel_oe | input | 1 | The target's own select driver is enabled |
| bus_free_req | input | 1 | Pulse: release the bus and clear the status |
| sel_ok | output | 1 | Selection succeeded |
| sel_atn | output | 1 | Attention flag of the current selection |
| sel_id | output | 3 | ID that was selected |
| scsi1_mode | output | 1 | Initiator did not raise attention at selection |
| bus_reset_seen | output | 1 | Filtered bus reset detected |
| bsy_oe | output | 1 | Drive busy |
| ctl_oe | output | 1 | Drive command/data and message at their inactive level |

## Verification
The bench goes after several corner cases. It holds busy high with a matching ID on the bus; a design that ignored busy would take the bus while another device still owns it. It places two matching IDs on the bus, one of them in a disabled slot; a wrong priority or a missed enable check gives the wrong sel_id. It changes attention exactly when busy is driven. A design that samples attention at detection time, instead of after the settle interval, reports the opposite compatibility mode in both directions. It sends reset pulses that are shorter and longer than the filter interval, and a long pulse while the target drives select; an unfiltered or ungated detector raises the reset flag on the short pulse or on the gated one.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_HOLD   = 2'd2
  } sel_ph_e;

  typedef enum logic {
    RF_IDLE = 1'b0,
    RF_WAIT = 1'b1
  } rf_ph_e;

  // Round a nanosecond interval up to whole clock cycles, at least one.
  function automatic int ns_to_cyc(input longint hz, input int ns);
    longint c;
    c = (longint'(ns) * (hz / 64'd1_000_000) + 64'd999) / 64'd1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tsr_id_pick.sv
module tsr_id_pick #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 3,
  localparam int BUS_W    = 1 << ID_W
) (
  input  logic [BUS_W-1:0]          mask,
  input  logic [NUM_SLOTS-1:0]      slot_en,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id,
  output logic                      hit,
  output logic [ID_W-1:0]           id
);
  // Walk from the highest slot down so the lowest matching slot is assigned last.
  always_comb begin
    hit = 1'b0;
    id  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_en[i] && mask[slot_id[i*ID_W +: ID_W]]) begin
        hit = 1'b1;
        id  = slot_id[i*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/tsr_rst_filter.sv
module tsr_rst_filter #(
  parameter int GAP_CYC = 50,
  localparam int CW     = $clog2(GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_s,
  input  logic own_sel_oe,
  output logic hit
);
  import tsr_pkg::*;

  rf_ph_e        ph;
  logic [CW-1:0] cnt;
  logic          prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= RF_IDLE;
      cnt  <= '0;
      prev <= 1'b0;
      hit  <= 1'b0;
    end else begin
      prev <= rst_s;
      hit  <= 1'b0;
      case (ph)
        RF_IDLE: begin
          // First sample: the rising edge itself, only when not driving select.
          if (rst_s && !prev && !own_sel_oe) begin
            ph  <= RF_WAIT;
            cnt <= '0;
          end
        end
        RF_WAIT: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            ph  <= RF_IDLE;
            hit <= rst_s;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsr_target_sel.sv
module tsr_target_sel #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int NUM_SLOTS  = 8,
  parameter int ID_W       = 3,
  parameter int SETTLE_NS  = 100,
  parameter int RST_GAP_NS = 500,
  localparam int BUS_W      = 1 << ID_W,
  localparam int SETTLE_CYC = tsr_pkg::ns_to_cyc(CLK_HZ, SETTLE_NS),
  localparam int GAP_CYC    = tsr_pkg::ns_to_cyc(CLK_HZ, RST_GAP_NS),
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_sel,
  input  logic                      bus_bsy,
  input  logic                      bus_atn,
  input  logic                      bus_rst,
  input  logic [BUS_W-1:0]          bus_data,
  input  logic [NUM_SLOTS-1:0]      slot_en,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id,
  input  logic                      own_sel_oe,
  input  logic                      bus_free_req,
  output logic                      sel_ok,
  output logic                      sel_atn,
  output logic [ID_W-1:0]           sel_id,
  output logic                      scsi1_mode,
  output logic                      bus_reset_seen,
  output logic                      bsy_oe,
  output logic                      ctl_oe
);
  import tsr_pkg::*;

  logic [3:0]       ctl_s;
  logic [BUS_W-1:0] data_s;
  logic             s_sel, s_bsy, s_atn, s_rst;
  logic             pick_hit;
  logic [ID_W-1:0]  pick_id;
  logic             rf_hit;
  sel_ph_e          ph;
  logic [CNT_W-1:0] cnt;

  tsr_sync #(.W(4)) sync_ctl_i (
    .clk (clk),
    .rst (rst),
    .d   ({bus_sel, bus_bsy, bus_atn, bus_rst}),
    .q   (ctl_s)
  );

  tsr_sync #(.W(BUS_W)) sync_data_i (
    .clk (clk),
    .rst (rst),
    .d   (bus_data),
    .q   (data_s)
  );

  assign {s_sel, s_bsy, s_atn, s_rst} = ctl_s;

  tsr_id_pick #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) pick_i (
    .mask    (data_s),
    .slot_en (slot_en),
    .slot_id (slot_id),
    .hit     (pick_hit),
    .id      (pick_id)
  );

  tsr_rst_filter #(.GAP_CYC(GAP_CYC)) rf_i (
    .clk        (clk),
    .rst        (rst),
    .rst_s      (s_rst),
    .own_sel_oe (own_sel_oe),
    .hit        (rf_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph             <= PH_IDLE;
      cnt            <= '0;
      sel_ok         <= 1'b0;
      sel_atn        <= 1'b0;
      sel_id         <= '0;
      scsi1_mode     <= 1'b0;
      bus_reset_seen <= 1'b0;
      bsy_oe         <= 1'b0;
      ctl_oe         <= 1'b0;
    end else if (bus_free_req) begin
      ph             <= PH_IDLE;
      cnt            <= '0;
      sel_ok         <= 1'b0;
      sel_atn        <= 1'b0;
      sel_id         <= '0;
      bus_reset_seen <= 1'b0;
      bsy_oe         <= 1'b0;
      ctl_oe         <= 1'b0;
    end else begin
      if (rf_hit) bus_reset_seen <= 1'b1;
      case (ph)
        PH_IDLE: begin
          // Level check covers both busy release and select-only initiators.
          if (s_sel && !s_bsy && pick_hit) begin
            ph      <= PH_SETTLE;
            cnt     <= '0;
            sel_ok  <= 1'b1;
            sel_atn <= 1'b1;
            sel_id  <= pick_id;
            bsy_oe  <= 1'b1;
            ctl_oe  <= 1'b1;
          end
        end
        PH_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            ph <= PH_HOLD;
            if (!s_atn) begin
              sel_atn    <= 1'b0;
              scsi1_mode <= 1'b1;
            end else begin
              scsi1_mode <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: ;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsr_target_sel_chk.sv
module tsr_target_sel_chk #(
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_free_req,
  input logic            sel_ok,
  input logic            sel_atn,
  input logic [ID_W-1:0] sel_id,
  input logic            scsi1_mode,
  input logic            bus_reset_seen,
  input logic            bsy_oe,
  input logic            ctl_oe
);
  AST_BSY_WITH_CTL: assert property (@(posedge clk) disable iff (rst)
    bsy_oe |-> ctl_oe); // R4

  AST_OK_HOLDS_BSY: assert property (@(posedge clk) disable iff (rst)
    sel_ok |-> bsy_oe); // R4

  AST_NEW_SEL_ATN: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ok) |-> sel_atn); // R4

  AST_ID_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && $past(sel_ok)) |-> $stable(sel_id)); // R7

  AST_COMPAT_NO_ATN: assert property (@(posedge clk) disable iff (rst)
    $rose(scsi1_mode) |-> !sel_atn); // R6

  AST_FREE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bus_free_req |=> (!sel_ok && !bsy_oe && !ctl_oe && !bus_reset_seen)); // R10
endmodule

bind tsr_target_sel tsr_target_sel_chk #(.ID_W(ID_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .bus_free_req   (bus_free_req),
  .sel_ok         (sel_ok),
  .sel_atn        (sel_atn),
  .sel_id         (sel_id),
  .scsi1_mode     (scsi1_mode),
  .bus_reset_seen (bus_reset_seen),
  .bsy_oe         (bsy_oe),
  .ctl_oe         (ctl_oe)
);

// File: tb/tsr_target_sel_tb_top.sv
module tsr_target_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_bsy = 1'b0, bus_atn = 1'b0, bus_rst = 1'b0;
  logic [7:0]  bus_data = '0;
  logic [7:0]  slot_en = '0;
  logic [23:0] slot_id = '0;
  logic        own_sel_oe = 1'b0, bus_free_req = 1'b0;
  logic        sel_ok, sel_atn, scsi1_mode, bus_reset_seen, bsy_oe, ctl_oe;
  logic [2:0]  sel_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    string      tag;
    logic [8:0] exp;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  tsr_target_sel dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_bsy(bus_bsy), .bus_atn(bus_atn),
    .bus_rst(bus_rst), .bus_data(bus_data), .slot_en(slot_en), .slot_id(slot_id),
    .own_sel_oe(own_sel_oe), .bus_free_req(bus_free_req), .sel_ok(sel_ok),
    .sel_atn(sel_atn), .sel_id(sel_id), .scsi1_mode(scsi1_mode),
    .bus_reset_seen(bus_reset_seen), .bsy_oe(bsy_oe), .ctl_oe(ctl_oe)
  );

  function automatic logic [8:0] ex(logic ok, logic atn, logic [2:0] id, logic s1,
                                     logic rf, logic bsy, logic ctl);
    return {ok, atn, id, s1, rf, bsy, ctl};
  endfunction

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      logic [8:0] act;
      it  = sb_q.pop_front();
      act = {sel_ok, sel_atn, sel_id, scsi1_mode, bus_reset_seen, bsy_oe, ctl_oe};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s act=%b exp=%b", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_now(string tag, logic [8:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    bus_sel = 1'b0;
    idle(4);
    bus_free_req = 1'b1;
    @(negedge clk);
    bus_free_req = 1'b0;
    idle(3);
  endtask

  task automatic wait_bsy();
    for (int i = 0; i < 30; i++) begin
      if (bsy_oe) break;
      @(negedge clk);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    // slot0 -> ID5, slot1 -> ID2, slot2 -> ID6
    slot_id = {15'd0, 3'd6, 3'd2, 3'd5};
    slot_en = 8'b0000_0111;
    idle(5);
    rst = 1'b0;
    idle(2);
    expect_now("R1 reset state", ex(0, 0, 0, 0, 0, 0, 0));

    // Busy held by another device blocks selection.
    bus_atn = 1'b0;
    bus_bsy = 1'b1;
    bus_data = 8'h20;
    bus_sel = 1'b1;
    idle(10);
    expect_now("R2 busy blocks", ex(0, 0, 0, 0, 0, 0, 0));
    bus_bsy = 1'b0;
    idle(5);
    expect_now("R4 provisional atn", ex(1, 1, 5, 0, 0, 1, 1));
    idle(15);
    expect_now("R6 atn low compat", ex(1, 0, 5, 1, 0, 1, 1));

    // Changes while driving busy are ignored.
    bus_data = 8'h04;
    bus_sel = 1'b0;
    idle(3);
    bus_sel = 1'b1;
    idle(8);
    expect_now("R7 ignored while busy", ex(1, 0, 5, 1, 0, 1, 1));
    bus_sel = 1'b0;
    idle(8);
    expect_now("R5 status latched", ex(1, 0, 5, 1, 0, 1, 1));
    release_bus();
    expect_now("R10 bus free", ex(0, 0, 0, 1, 0, 0, 0));

    // Select-only initiator, priority between two matches, atn high.
    bus_atn = 1'b1;
    bus_data = 8'h44;
    bus_sel = 1'b1;
    idle(25);
    expect_now("R11 R3 priority atn high", ex(1, 1, 2, 0, 0, 1, 1));
    release_bus();

    // No enabled slot matches.
    bus_data = 8'h08;
    bus_sel = 1'b1;
    idle(20);
    expect_now("R3 no match", ex(0, 0, 0, 0, 0, 0, 0));
    bus_sel = 1'b0;
    idle(4);

    // Disabled slot skipped.
    slot_en = 8'b0000_0101;
    bus_data = 8'h44;
    bus_sel = 1'b1;
    idle(25);
    expect_now("R3 disabled slot", ex(1, 1, 6, 0, 0, 1, 1));
    release_bus();
    slot_en = 8'b0000_0111;

    // Attention rises just as busy is driven: must count as present.
    bus_atn = 1'b0;
    bus_data = 8'h20;
    bus_sel = 1'b1;
    wait_bsy();
    bus_atn = 1'b1;
    idle(20);
    expect_now("R6 atn late high", ex(1, 1, 5, 0, 0, 1, 1));
    release_bus();

    // Attention drops just as busy is driven: must count as absent.
    bus_atn = 1'b1;
    bus_data = 8'h20;
    bus_sel = 1'b1;
    wait_bsy();
    bus_atn = 1'b0;
    idle(20);
    expect_now("R6 atn late low", ex(1, 0, 5, 1, 0, 1, 1));
    release_bus();

    // Reset glitch shorter than the filter interval.
    bus_rst = 1'b1;
    idle(20);
    bus_rst = 1'b0;
    idle(70);
    expect_now("R8 short pulse", ex(0, 0, 0, 1, 0, 0, 0));

    // Long reset pulse.
    bus_rst = 1'b1;
    idle(80);
    bus_rst = 1'b0;
    idle(10);
    expect_now("R8 long pulse", ex(0, 0, 0, 1, 1, 0, 0));
    release_bus();
    expect_now("R10 clears reset flag", ex(0, 0, 0, 1, 0, 0, 0));

    // Reset while the target drives select.
    own_sel_oe = 1'b1;
    idle(2);
    bus_rst = 1'b1;
    idle(80);
    bus_rst = 1'b0;
    idle(10);
    expect_now("R9 gated by own select", ex(0, 0, 0, 1, 0, 0, 0));
    own_sel_oe = 1'b0;
    idle(4);

    done = 1'b1;
    report();
  end
endmodule